// File: doc/BRIEF.md
# Multi-mode addressable bit latch

This block keeps a small bank of single-bit storage cells. One data line is steered into one cell, and a binary index picks that cell. Two active-low controls, a write enable and a clear, are decoded into four operating modes. The first mode writes the indexed cell. The second holds every cell. The third drives a one-hot pattern, in which only the indexed output carries the data bit and all others are forced low. The fourth forces every output low.

Storage changes only on the rising edge of the system clock. In the decode and clear modes the outputs react at once, with no wait for the edge. At the next edge the storage takes on the pattern being shown. A designer can use the block as a serial-to-parallel register, where bits are written one at a time at chosen positions. It can also serve as an active-high one-of-N decoder whose last pattern persists once the controls return to hold. A separate synchronous reset zeroes the storage.

Top module: `bitsel_latch`

## Requirements
- R1: When rst_n is low at a rising clock edge, every stored bit becomes 0, so a following hold shows q_out == 0.
- R2: With en_n=0 and clr_n=1 (write mode) at a rising edge, the stored bit at index sel_addr takes the value of din.
- R3: In write mode, every stored bit other than the indexed one keeps its value across the edge.
- R4: With en_n=1 and clr_n=1 (hold mode), q_out shows the stored bits, and no change of din or sel_addr alters them.
- R5: With en_n=0 and clr_n=0 (decode mode), q_out shows din at index sel_addr and 0 at every other index, in the same cycle the inputs are applied.
- R6: After a rising edge in decode mode, the stored bits equal the decoded pattern, so a following hold keeps showing it.
- R7: With en_n=1 and clr_n=0 (clear mode), q_out is 0 in the same cycle, and after the edge every stored bit is 0.
- R8: sel_addr is an unsigned binary index with bit 0 as its least significant bit, and value k selects q_out[k].
- R9: Mode encoding as {clr_n,en_n}: 2'b10 write, 2'b11 hold, 2'b00 decode, 2'b01 clear. When clr_n is low it takes priority over storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the stored bits |
| sel_addr | input | 3 | Binary index of the target bit |
| din | input | 1 | Data bit to write or decode |
| en_n | input | 1 | Active-low write/decode enable |
| clr_n | input | 1 | Active-low clear/decode select |
| q_out | output | 8 | Parallel view of the bits |

## Verification
On every cycle, the assertions check three things. They check the same-cycle output shape in clear and decode mode, that outputs stay steady across back-to-back holds, and that a write or decode edge leaves the expected bit or pattern visible at the next hold. Other behaviour shows only in the bench's scenarios. These include cells outside the index keeping their values through a long series of writes, the exact bit order of the index, and the recovery of a full byte built up bit by bit. Random mixes of all four modes, compared against a cycle model, cover the orderings between modes.

// File: rtl/bitsel_pkg.sv
package bitsel_pkg;
    typedef enum logic [1:0] {
        MODE_WRITE  = 2'd0,
        MODE_HOLD   = 2'd1,
        MODE_DECODE = 2'd2,
        MODE_ZERO   = 2'd3
    } bitsel_mode_e;
endpackage

// File: rtl/bitsel_mode_dec.sv
module bitsel_mode_dec
    import bitsel_pkg::*;
(
    input  logic         en_n,
    input  logic         clr_n,
    output bitsel_mode_e mode
);
    always_comb begin
        unique case ({clr_n, en_n})
            2'b10:   mode = MODE_WRITE;
            2'b11:   mode = MODE_HOLD;
            2'b00:   mode = MODE_DECODE;
            default: mode = MODE_ZERO;
        endcase
    end
endmodule

// File: rtl/bitsel_addr_dec.sv
module bitsel_addr_dec #(
    parameter int ADDR_W   = 3,
    parameter int NUM_BITS = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_BITS-1:0] hot
);
    for (genvar i = 0; i < NUM_BITS; i++) begin : g_line
        assign hot[i] = (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/bitsel_latch.sv
module bitsel_latch
    import bitsel_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          sel_addr,
    input  logic                       din,
    input  logic                       en_n,
    input  logic                       clr_n,
    output logic [(1 << ADDR_W)-1:0]   q_out
);
    localparam int NUM_BITS = 1 << ADDR_W;

    typedef struct packed {
        logic [NUM_BITS-1:0] bits;
    } latch_state_t;

    latch_state_t        state_d, state_q;
    bitsel_mode_e        mode;
    logic [NUM_BITS-1:0] hot;
    logic [NUM_BITS-1:0] pattern;

    bitsel_mode_dec i_mode_dec (
        .en_n  (en_n),
        .clr_n (clr_n),
        .mode  (mode)
    );

    bitsel_addr_dec #(
        .ADDR_W   (ADDR_W),
        .NUM_BITS (NUM_BITS)
    ) i_addr_dec (
        .addr (sel_addr),
        .hot  (hot)
    );

    assign pattern = hot & {NUM_BITS{din}};

    always_comb begin
        state_d = state_q;
        unique case (mode)
            MODE_WRITE:  state_d.bits = (state_q.bits & ~hot) | pattern;
            MODE_HOLD:   state_d.bits = state_q.bits;
            MODE_DECODE: state_d.bits = pattern;
            default:     state_d.bits = '0;
        endcase
        if (!rst_n) begin
            state_d.bits = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        unique case (mode)
            MODE_DECODE: q_out = pattern;
            MODE_ZERO:   q_out = '0;
            default:     q_out = state_q.bits;
        endcase
    end
endmodule

// File: rtl/bitsel_latch_chk.sv
module bitsel_latch_chk #(
    parameter int ADDR_W = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        sel_addr,
    input logic                     din,
    input logic                     en_n,
    input logic                     clr_n,
    input logic [(1 << ADDR_W)-1:0] q_out
);
    localparam int NUM_BITS = 1 << ADDR_W;

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && en_n && clr_n) |-> (q_out == '0));

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!en_n && clr_n) && en_n && clr_n)
        |-> (q_out[$past(sel_addr)] == $past(din)));

    // R4
    hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en_n && clr_n) && en_n && clr_n) |-> $stable(q_out));

    // R5
    decode_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !clr_n)
        |-> ($onehot0(q_out) && (q_out[sel_addr] == din)
             && ($countones(q_out) == int'(din))));

    // R6
    decode_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!en_n && !clr_n) && en_n && clr_n)
        |-> (q_out == ({{(NUM_BITS-1){1'b0}}, $past(din)} << $past(sel_addr))));

    // R7
    clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n && !clr_n) |-> (q_out == '0));
endmodule

bind bitsel_latch bitsel_latch_chk #(.ADDR_W(ADDR_W)) i_bitsel_latch_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_addr (sel_addr),
    .din      (din),
    .en_n     (en_n),
    .clr_n    (clr_n),
    .q_out    (q_out)
);

// File: tb/test_bitsel_latch.sv
`timescale 1ns/1ps
module test_bitsel_latch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel_addr = '0;
    logic       din = 1'b0;
    logic       en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [7:0] q_out;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [7:0] model_q = '0;
    string      last_kind = "R1";

    always #4 clk = ~clk;

    bitsel_latch i_bitsel_latch (
        .clk(clk), .rst_n(rst_n), .sel_addr(sel_addr), .din(din),
        .en_n(en_n), .clr_n(clr_n), .q_out(q_out)
    );

    function automatic logic [7:0] view(input logic e, input logic c, input logic d,
                                        input logic [2:0] a, input logic [7:0] m);
        if (!c) return e ? 8'h00 : (8'(d) << a);
        return m;
    endfunction

    function automatic logic [7:0] next_state(input logic e, input logic c, input logic d,
                                              input logic [2:0] a, input logic [7:0] m);
        logic [7:0] r;
        r = m;
        case ({c, e})
            2'b10: r[a] = d;
            2'b11: r = m;
            2'b00: r = 8'(d) << a;
            default: r = 8'h00;
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: q_out=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic e, input logic c, input logic d,
                        input logic [2:0] a, input string tag);
        string t;
        @(negedge clk);
        en_n = e; clr_n = c; din = d; sel_addr = a;
        #1;
        if (tag != "") t = tag;
        else if (!c) t = e ? "R7" : "R5";
        else t = last_kind;
        check(t, q_out, view(e, c, d, a, model_q));
        @(posedge clk);
        model_q = next_state(e, c, d, a, model_q);
        case ({c, e})
            2'b10: last_kind = "R2";
            2'b11: last_kind = (last_kind == "R1") ? "R1" : "R4";
            2'b00: last_kind = "R6";
            default: last_kind = "R7";
        endcase
    endtask

    task automatic hold_probe(input logic [7:0] exp, input string tag);
        @(negedge clk);
        en_n = 1'b1; clr_n = 1'b1; din = ~din; sel_addr = sel_addr + 3'd3;
        #1;
        check(tag, q_out, exp);
        @(posedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset with storage dirty from a decode attempt under reset
        en_n = 1'b0; clr_n = 1'b0; din = 1'b1; sel_addr = 3'd6;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; en_n = 1'b1; clr_n = 1'b1;
        #1;
        check("R1", q_out, 8'h00);
        model_q = '0;
        // R8: one write per index, each visible alone
        for (int k = 0; k < 8; k++) begin
            step(1'b0, 1'b1, 1'b1, 3'(k), "R2");
            hold_probe(8'h01 << k, "R8");
            step(1'b0, 1'b1, 1'b0, 3'(k), "R2");
        end
        // R3: build full byte, then clear one bit
        for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 1'b1, 3'(k), "R3");
        hold_probe(8'hFF, "R3");
        step(1'b0, 1'b1, 1'b0, 3'd2, "R3");
        hold_probe(8'hFB, "R3");
        // R4: hold ignores data and address wiggle
        for (int k = 0; k < 8; k++) step(1'b1, 1'b1, k[0], 3'(k), "R4");
        hold_probe(8'hFB, "R4");
        // R9: mode encoding at the edges of the table
        step(1'b0, 1'b0, 1'b1, 3'd3, "R9");
        hold_probe(8'h08, "R6");
        step(1'b0, 1'b0, 1'b0, 3'd7, "R5");
        hold_probe(8'h00, "R6");
        for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 1'b1, 3'(k), "R2");
        step(1'b1, 1'b0, 1'b1, 3'd5, "R9");
        hold_probe(8'h00, "R7");
        // random mix of all modes
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], (r[3:1] != 3'd0), r[4], r[7:5], "");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule